// File: doc/BRIEF.md
# Exception Cause Detection and Vector Selection Unit

This unit sits next to the completion stage of a simple in-order core. On every clock it looks at the status flags of the instruction that is completing and at the machine-state control bits. It also watches the most significant bit of the decrementer register. From these it decides whether an exception is taken. When one is taken, the unit gives one vector offset, a one-hot program sub-cause for the saved-status register, and a take strobe. All three are registered, so they appear one clock after the inputs that caused them.

Several conditions can be present in the same cycle. A fixed priority then chooses exactly one of them. The decrementer interrupt is edge-triggered. A rise of the decrementer's top bit that arrives while external interrupts are masked is held as pending. It is taken later, once the enable bit is set.

The completing-instruction flags are qualified by `cmp_valid`. There is no back-pressure. The unit accepts a new set of flags on every clock and never stalls the core, so the interface has no ready signal. The decrementer input is sampled on every clock, whatever `cmp_valid` is.

Top module: `exc_vector_unit`

## Requirements
- R1: With `cmp_valid`=1, an illegal opcode raises offset 0x00700 with `exc_prog`=4'b0001. So does an unimplemented optional instruction, unless it is flagged as one executed as a no-op, in which case nothing is raised.
- R2: With `cmp_valid`=1 and `user_mode`=1, a privileged operation raises offset 0x00700 with `exc_prog`=4'b0010. A special-register move also raises it when its register number is unrecognised and the most significant bit of that number is 1. Neither case raises anything when `user_mode`=0, and the register case raises nothing when that bit is 0.
- R3: With `cmp_valid`=1, a satisfied trap condition raises offset 0x00700 with `exc_prog`=4'b0100.
- R4: With `cmp_valid`=1, (`fpx_mode0` OR `fpx_mode1`) AND `fp_summary` raises offset 0x00700 with `exc_prog`=4'b1000.
- R5: With `cmp_valid`=1, a floating-point instruction raises offset 0x00800 when `fp_enable`=0. This covers loads, stores and moves. With `fp_enable`=1 it raises nothing.
- R6: A 0-to-1 transition of `dec_msb` while `ext_int_en`=1 raises offset 0x00900. A `dec_msb` that stays at 1 raises nothing further.
- R7: A 0-to-1 transition of `dec_msb` while `ext_int_en`=0 is held as pending. It is taken at offset 0x00900 in the first cycle in which `ext_int_en`=1 and no higher-priority cause is present, and taking it clears it.
- R8: With `cmp_valid`=1, a system call raises offset 0x00C00.
- R9: With `cmp_valid`=1, a trace exception at offset 0x00D00 is raised in either of two cases: `single_step`=1, or `op_branch`=1 with `branch_trace`=1.
- R10: With `cmp_valid`=1, an instruction translation miss raises offset 0x01000.
- R11: When several causes are present, exactly one is reported. The order, from highest to lowest, is: translation miss, illegal, privileged, floating-point unavailable, floating-point enabled, trap, system call, trace, decrementer.
- R12: Outputs are registered one cycle after their inputs. When `exc_take`=0, `exc_vec` and `exc_prog` are 0. `exc_prog` is nonzero only with offset 0x00700. Its bit order is 0 illegal, 1 privileged, 2 trap, 3 floating-point enabled.
- R13: With `cmp_valid`=0, no instruction flag raises anything.
- R14: After reset all outputs are 0, and the offsets 0x00A00–0x00BFF and 0x00E00–0x00FFF are never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | An instruction is completing this cycle |
| op_illegal | input | 1 | Illegal opcode or illegal opcode/extended-opcode pair |
| op_unimpl_opt | input | 1 | Optional instruction that is not implemented |
| op_opt_nop | input | 1 | The unimplemented optional instruction is executed as a no-op |
| op_priv | input | 1 | Privileged instruction |
| spr_access | input | 1 | Move to or from a special register |
| spr_known | input | 1 | The special-register number is recognised |
| spr_sel_hi | input | 1 | Most significant bit of the special-register number |
| user_mode | input | 1 | Processor is in user (problem) state |
| op_fp | input | 1 | Floating-point instruction, including loads, stores and moves |
| fp_enable | input | 1 | Floating-point unit is available |
| fpx_mode0 | input | 1 | Floating-point exception mode bit 0 |
| fpx_mode1 | input | 1 | Floating-point exception mode bit 1 |
| fp_summary | input | 1 | Floating-point enabled-exception summary |
| trap_hit | input | 1 | A trap instruction's condition is met |
| op_syscall | input | 1 | System call instruction |
| op_branch | input | 1 | Completing instruction is a branch |
| single_step | input | 1 | Single-step trace enable |
| branch_trace | input | 1 | Branch trace enable |
| itlb_miss | input | 1 | Instruction fetch address missed in the instruction TLB |
| dec_msb | input | 1 | Decrementer most significant bit |
| ext_int_en | input | 1 | External interrupt enable |
| exc_take | output | 1 | Exception taken (registered) |
| exc_vec | output | VEC_W | Vector offset of the taken exception |
| exc_prog | output | 4 | One-hot program sub-cause |

## Verification
The main overlap is a decrementer rise in the same cycle as an instruction exception. The bench raises `dec_msb` with interrupts enabled while a single-step instruction completes. It then expects offset 0x00D00 first and offset 0x00900 one cycle later. The second result shows that the losing decrementer edge was kept as pending and not lost. Overlaps between instruction causes are produced by rows of the vector table that assert several flags at once, and each row is judged against the single highest-ranked vector and sub-cause.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VOFF_W = 20;
  localparam int N_SRC  = 9;

  // source index == priority rank (0 highest)
  localparam int P_ITLB = 0;
  localparam int P_ILL  = 1;
  localparam int P_PRIV = 2;
  localparam int P_FPU  = 3;
  localparam int P_FPE  = 4;
  localparam int P_TRAP = 5;
  localparam int P_SC   = 6;
  localparam int P_TRC  = 7;
  localparam int P_DEC  = 8;

  // program sub-cause field bit positions
  localparam int PC_W    = 4;
  localparam int PC_ILL  = 0;
  localparam int PC_PRIV = 1;
  localparam int PC_TRAP = 2;
  localparam int PC_FPE  = 3;

  function automatic logic [VOFF_W-1:0] src_offset(input int idx);
    case (idx)
      P_ITLB:                     return 20'h01000;
      P_ILL, P_PRIV, P_FPE, P_TRAP: return 20'h00700;
      P_FPU:                      return 20'h00800;
      P_SC:                       return 20'h00C00;
      P_TRC:                      return 20'h00D00;
      P_DEC:                      return 20'h00900;
      default:                    return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_pkg::*;
(
  input  logic             cmp_valid,
  input  logic             op_illegal,
  input  logic             op_unimpl_opt,
  input  logic             op_opt_nop,
  input  logic             op_priv,
  input  logic             spr_access,
  input  logic             spr_known,
  input  logic             spr_sel_hi,
  input  logic             user_mode,
  input  logic             op_fp,
  input  logic             fp_enable,
  input  logic             fpx_mode0,
  input  logic             fpx_mode1,
  input  logic             fp_summary,
  input  logic             trap_hit,
  input  logic             op_syscall,
  input  logic             op_branch,
  input  logic             single_step,
  input  logic             branch_trace,
  input  logic             itlb_miss,
  output logic [N_SRC-1:0] req_o
);
  logic ill_c, priv_c, spr_bad, fpe_c, trc_c;

  assign ill_c   = op_illegal | (op_unimpl_opt & ~op_opt_nop);
  assign spr_bad = spr_access & ~spr_known & spr_sel_hi;
  assign priv_c  = user_mode & (op_priv | spr_bad);
  assign fpe_c   = (fpx_mode0 | fpx_mode1) & fp_summary;
  assign trc_c   = single_step | (op_branch & branch_trace);

  always_comb begin
    req_o         = '0;
    req_o[P_ITLB] = cmp_valid & itlb_miss;
    req_o[P_ILL]  = cmp_valid & ill_c;
    req_o[P_PRIV] = cmp_valid & priv_c;
    req_o[P_FPU]  = cmp_valid & op_fp & ~fp_enable;
    req_o[P_FPE]  = cmp_valid & fpe_c;
    req_o[P_TRAP] = cmp_valid & trap_hit;
    req_o[P_SC]   = cmp_valid & op_syscall;
    req_o[P_TRC]  = cmp_valid & trc_c;
  end
endmodule

// File: rtl/exc_dec_edge.sv
module exc_dec_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_msb,
  input  logic ext_int_en,
  input  logic dec_taken_i,
  output logic dec_req_o
);
  logic msb_q, pend_q, rise, avail;

  assign rise      = dec_msb & ~msb_q;
  assign avail     = pend_q | rise;
  assign dec_req_o = avail & ext_int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      msb_q  <= dec_msb;
      pend_q <= avail & ~dec_taken_i;
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N-1:0] blk;

  assign blk[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_grant
    assign grant_o[gi] = req_i[gi] & ~blk[gi];
  end

  for (genvar gj = 0; gj < N - 1; gj++) begin : g_chain
    assign blk[gj+1] = blk[gj] | req_i[gj];
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int VEC_W = VOFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             op_illegal,
  input  logic             op_unimpl_opt,
  input  logic             op_opt_nop,
  input  logic             op_priv,
  input  logic             spr_access,
  input  logic             spr_known,
  input  logic             spr_sel_hi,
  input  logic             user_mode,
  input  logic             op_fp,
  input  logic             fp_enable,
  input  logic             fpx_mode0,
  input  logic             fpx_mode1,
  input  logic             fp_summary,
  input  logic             trap_hit,
  input  logic             op_syscall,
  input  logic             op_branch,
  input  logic             single_step,
  input  logic             branch_trace,
  input  logic             itlb_miss,
  input  logic             dec_msb,
  input  logic             ext_int_en,
  output logic             exc_take,
  output logic [VEC_W-1:0] exc_vec,
  output logic [PC_W-1:0]  exc_prog
);
  logic [N_SRC-1:0] ins_req, req, grant;
  logic             dec_req;
  logic [VEC_W-1:0] vec_d;
  logic [PC_W-1:0]  prog_d;

  exc_cause_decode u_dec (
    .cmp_valid    (cmp_valid),
    .op_illegal   (op_illegal),
    .op_unimpl_opt(op_unimpl_opt),
    .op_opt_nop   (op_opt_nop),
    .op_priv      (op_priv),
    .spr_access   (spr_access),
    .spr_known    (spr_known),
    .spr_sel_hi   (spr_sel_hi),
    .user_mode    (user_mode),
    .op_fp        (op_fp),
    .fp_enable    (fp_enable),
    .fpx_mode0    (fpx_mode0),
    .fpx_mode1    (fpx_mode1),
    .fp_summary   (fp_summary),
    .trap_hit     (trap_hit),
    .op_syscall   (op_syscall),
    .op_branch    (op_branch),
    .single_step  (single_step),
    .branch_trace (branch_trace),
    .itlb_miss    (itlb_miss),
    .req_o        (ins_req)
  );

  exc_dec_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_msb    (dec_msb),
    .ext_int_en (ext_int_en),
    .dec_taken_i(grant[P_DEC]),
    .dec_req_o  (dec_req)
  );

  always_comb begin
    req        = ins_req;
    req[P_DEC] = dec_req;
  end

  exc_prio_sel #(.N(N_SRC)) u_prio (
    .req_i  (req),
    .grant_o(grant)
  );

  // one-hot grant -> offset; OR of at most one term
  always_comb begin
    vec_d = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) vec_d = vec_d | VEC_W'(src_offset(i));
    end
  end

  always_comb begin
    prog_d          = '0;
    prog_d[PC_ILL]  = grant[P_ILL];
    prog_d[PC_PRIV] = grant[P_PRIV];
    prog_d[PC_TRAP] = grant[P_TRAP];
    prog_d[PC_FPE]  = grant[P_FPE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_take <= 1'b0;
      exc_vec  <= '0;
      exc_prog <= '0;
    end else begin
      exc_take <= |grant;
      exc_vec  <= vec_d;
      exc_prog <= prog_d;
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int VEC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic             itlb_miss,
  input logic             ext_int_en,
  input logic             exc_take,
  input logic [VEC_W-1:0] exc_vec,
  input logic [3:0]       exc_prog
);
  localparam logic [VEC_W-1:0] V_PROG = VEC_W'(20'h00700);
  localparam logic [VEC_W-1:0] V_DEC  = VEC_W'(20'h00900);
  localparam logic [VEC_W-1:0] V_ITLB = VEC_W'(20'h01000);

  a_r14_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> !((exc_vec >= VEC_W'(20'h00A00) && exc_vec <= VEC_W'(20'h00BFF)) ||
                   (exc_vec >= VEC_W'(20'h00E00) && exc_vec <= VEC_W'(20'h00FFF))));

  a_r12_prog_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_prog));

  a_r12_prog_only_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_prog != 4'b0) |-> (exc_take && exc_vec == V_PROG));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> (exc_vec == '0 && exc_prog == 4'b0));

  a_r10_itlb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && itlb_miss) |=> (exc_take && exc_vec == V_ITLB));

  a_r6_dec_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_vec == V_DEC) |-> $past(ext_int_en));

  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !ext_int_en) |=> !exc_take);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .itlb_miss (itlb_miss),
  .ext_int_en(ext_int_en),
  .exc_take  (exc_take),
  .exc_vec   (exc_vec),
  .exc_prog  (exc_prog)
);

// File: tb/tb_exc_vector_unit.sv
module tb_exc_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 2000;

  // stimulus flag bits
  localparam logic [19:0] F_V    = 20'h00001;
  localparam logic [19:0] F_ILL  = 20'h00002;
  localparam logic [19:0] F_UNI  = 20'h00004;
  localparam logic [19:0] F_NOP  = 20'h00008;
  localparam logic [19:0] F_PRIV = 20'h00010;
  localparam logic [19:0] F_SPR  = 20'h00020;
  localparam logic [19:0] F_SKN  = 20'h00040;
  localparam logic [19:0] F_SHI  = 20'h00080;
  localparam logic [19:0] F_PR   = 20'h00100;
  localparam logic [19:0] F_FP   = 20'h00200;
  localparam logic [19:0] F_FPA  = 20'h00400;
  localparam logic [19:0] F_FE0  = 20'h00800;
  localparam logic [19:0] F_FE1  = 20'h01000;
  localparam logic [19:0] F_FEX  = 20'h02000;
  localparam logic [19:0] F_TRAP = 20'h04000;
  localparam logic [19:0] F_SC   = 20'h08000;
  localparam logic [19:0] F_BR   = 20'h10000;
  localparam logic [19:0] F_SE   = 20'h20000;
  localparam logic [19:0] F_BE   = 20'h40000;
  localparam logic [19:0] F_ITLB = 20'h80000;

  typedef struct packed {
    logic [19:0] fl;
    logic        tk;
    logic [19:0] vec;
    logic [3:0]  cs;
    logic [7:0]  rq;
  } row_t;

  localparam int NROW = 31;
  localparam row_t TBL [NROW] = '{
    '{F_V|F_ILL,                    1'b1, 20'h00700, 4'b0001, 8'd1},   // R1
    '{F_V|F_UNI,                    1'b1, 20'h00700, 4'b0001, 8'd1},   // R1
    '{F_V|F_UNI|F_NOP,              1'b0, 20'h00000, 4'b0000, 8'd1},   // R1 no-op exempt
    '{F_V|F_PRIV|F_PR,              1'b1, 20'h00700, 4'b0010, 8'd2},   // R2
    '{F_V|F_PRIV,                   1'b0, 20'h00000, 4'b0000, 8'd2},   // R2 supervisor
    '{F_V|F_SPR|F_SHI|F_PR,         1'b1, 20'h00700, 4'b0010, 8'd2},   // R2 bad spr
    '{F_V|F_SPR|F_SHI|F_SKN|F_PR,   1'b0, 20'h00000, 4'b0000, 8'd2},   // R2 known spr
    '{F_V|F_SPR|F_PR,               1'b0, 20'h00000, 4'b0000, 8'd2},   // R2 msb 0
    '{F_V|F_TRAP,                   1'b1, 20'h00700, 4'b0100, 8'd3},   // R3
    '{F_V|F_FE0|F_FEX,              1'b1, 20'h00700, 4'b1000, 8'd4},   // R4
    '{F_V|F_FE1|F_FEX,              1'b1, 20'h00700, 4'b1000, 8'd4},   // R4
    '{F_V|F_FEX,                    1'b0, 20'h00000, 4'b0000, 8'd4},   // R4 modes off
    '{F_V|F_FE0,                    1'b0, 20'h00000, 4'b0000, 8'd4},   // R4 summary off
    '{F_V|F_FP,                     1'b1, 20'h00800, 4'b0000, 8'd5},   // R5
    '{F_V|F_FP|F_FPA,               1'b0, 20'h00000, 4'b0000, 8'd5},   // R5 available
    '{F_V|F_SC,                     1'b1, 20'h00C00, 4'b0000, 8'd8},   // R8
    '{F_V|F_SE,                     1'b1, 20'h00D00, 4'b0000, 8'd9},   // R9
    '{F_V|F_BR|F_BE,                1'b1, 20'h00D00, 4'b0000, 8'd9},   // R9
    '{F_V|F_BR,                     1'b0, 20'h00000, 4'b0000, 8'd9},   // R9
    '{F_V|F_BE,                     1'b0, 20'h00000, 4'b0000, 8'd9},   // R9
    '{F_V|F_ITLB,                   1'b1, 20'h01000, 4'b0000, 8'd10},  // R10
    '{F_ITLB|F_ILL|F_SC|F_SE,       1'b0, 20'h00000, 4'b0000, 8'd13},  // R13
    '{F_V|F_ITLB|F_ILL|F_PRIV|F_PR|F_SC, 1'b1, 20'h01000, 4'b0000, 8'd11}, // R11
    '{F_V|F_ILL|F_PRIV|F_PR|F_TRAP, 1'b1, 20'h00700, 4'b0001, 8'd11},  // R11
    '{F_V|F_PRIV|F_PR|F_FP|F_TRAP,  1'b1, 20'h00700, 4'b0010, 8'd11},  // R11
    '{F_V|F_FP|F_FE0|F_FEX|F_TRAP,  1'b1, 20'h00800, 4'b0000, 8'd11},  // R11
    '{F_V|F_FE0|F_FEX|F_TRAP,       1'b1, 20'h00700, 4'b1000, 8'd11},  // R11
    '{F_V|F_TRAP|F_SC,              1'b1, 20'h00700, 4'b0100, 8'd11},  // R11
    '{F_V|F_SC|F_SE,                1'b1, 20'h00C00, 4'b0000, 8'd11},  // R11
    '{F_V|F_SE|F_BR|F_BE,           1'b1, 20'h00D00, 4'b0000, 8'd9},   // R9
    '{F_V,                          1'b0, 20'h00000, 4'b0000, 8'd12}   // R12
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] fl;
  logic        dec_msb, ext_int_en;
  logic        exc_take;
  logic [19:0] exc_vec;
  logic [3:0]  exc_prog;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_valid    (fl[0]),
    .op_illegal   (fl[1]),
    .op_unimpl_opt(fl[2]),
    .op_opt_nop   (fl[3]),
    .op_priv      (fl[4]),
    .spr_access   (fl[5]),
    .spr_known    (fl[6]),
    .spr_sel_hi   (fl[7]),
    .user_mode    (fl[8]),
    .op_fp        (fl[9]),
    .fp_enable    (fl[10]),
    .fpx_mode0    (fl[11]),
    .fpx_mode1    (fl[12]),
    .fp_summary   (fl[13]),
    .trap_hit     (fl[14]),
    .op_syscall   (fl[15]),
    .op_branch    (fl[16]),
    .single_step  (fl[17]),
    .branch_trace (fl[18]),
    .itlb_miss    (fl[19]),
    .dec_msb      (dec_msb),
    .ext_int_en   (ext_int_en),
    .exc_take     (exc_take),
    .exc_vec      (exc_vec),
    .exc_prog     (exc_prog)
  );

  task automatic chk(input string tag, input logic tk, input logic [19:0] v,
                     input logic [3:0] cs);
    n_tests++;
    if (exc_take !== tk || exc_vec !== v || exc_prog !== cs) begin
      n_fail++;
      $display("FAIL %s: got take=%0b vec=%05h prog=%04b, expected take=%0b vec=%05h prog=%04b",
               tag, exc_take, exc_vec, exc_prog, tk, v, cs);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fl = '0; dec_msb = 1'b0; ext_int_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R14 reset", 1'b0, 20'h0, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 after reset", 1'b0, 20'h0, 4'b0);

    // table walk: inputs at negedge, registered result one negedge later
    for (int i = 0; i < NROW; i++) begin
      fl = TBL[i].fl;
      @(negedge clk);
      chk($sformatf("R%0d row %0d", TBL[i].rq, i), TBL[i].tk, TBL[i].vec, TBL[i].cs);
    end
    fl = '0;
    @(negedge clk);
    chk("R12 strobe drops", 1'b0, 20'h0, 4'b0);

    // R6: edge with enable set, then steady high
    ext_int_en = 1'b1; dec_msb = 1'b1;
    @(negedge clk);
    chk("R6 rise", 1'b1, 20'h00900, 4'b0);
    @(negedge clk);
    chk("R6 level high", 1'b0, 20'h0, 4'b0);
    dec_msb = 1'b0;
    @(negedge clk);
    chk("R6 fall", 1'b0, 20'h0, 4'b0);

    // R7: rise while masked, taken once enabled, then cleared
    ext_int_en = 1'b0; dec_msb = 1'b1;
    @(negedge clk);
    chk("R7 masked", 1'b0, 20'h0, 4'b0);
    @(negedge clk);
    chk("R7 still masked", 1'b0, 20'h0, 4'b0);
    ext_int_en = 1'b1;
    @(negedge clk);
    chk("R7 pending taken", 1'b1, 20'h00900, 4'b0);
    @(negedge clk);
    chk("R7 pending cleared", 1'b0, 20'h0, 4'b0);
    dec_msb = 1'b0;
    @(negedge clk);

    // R11: decrementer edge loses to trace, then follows
    dec_msb = 1'b1; fl = F_V | F_SE;
    @(negedge clk);
    chk("R11 trace over dec", 1'b1, 20'h00D00, 4'b0);
    fl = '0;
    @(negedge clk);
    chk("R11 dec after trace", 1'b1, 20'h00900, 4'b0);
    @(negedge clk);
    chk("R11 dec once", 1'b0, 20'h0, 4'b0);

    // R13: pending decrementer with valid low still taken, instr flags ignored
    dec_msb = 1'b0; ext_int_en = 1'b0;
    @(negedge clk);
    dec_msb = 1'b1;
    @(negedge clk);
    fl = F_SC | F_ILL; ext_int_en = 1'b1;
    @(negedge clk);
    chk("R13 dec with valid low", 1'b1, 20'h00900, 4'b0);

    // R14: reset mid-flight clears outputs and pending
    fl = F_V | F_SC;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R14 async reset", 1'b0, 20'h0, 4'b0);
    fl = '0; dec_msb = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 idle after reset", 1'b0, 20'h0, 4'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule